// File: doc/BRIEF.md
# Threshold Flag with Sample-Count Hysteresis

This block watches a stream of already-filtered samples and raises a single flag when the signal has sat on one side of a programmable threshold long enough. Each sample that arrives with its valid strobe is compared against the threshold. The flag sets only after a programmed number of consecutive qualifying samples. Once set, it clears only after a separately programmed number of consecutive non-qualifying samples. Using two independent run lengths gives hysteresis in time rather than in amplitude, which removes glitches in both directions.

A one-bit type input picks the direction of the comparison. In above mode a sample qualifies when it is at or over the threshold. In below mode it qualifies when it is strictly under the threshold. The comparison is unsigned. The state machine has two states. `ST_LOW` means the flag is clear and a qualifying run is being counted. `ST_HIGH` means the flag is set and a non-qualifying run is being counted. The transition from `ST_LOW` to `ST_HIGH` is called "arm complete". The transition back is called "release complete". On either transition both run counters restart from zero.

Top module: `thresh_flag`

## Requirements
- R1: While `rst_n` is low, and after it is released until a run completes, `flag_o` is 0 and both run counts are zero.
- R2: With `cfg_below` = 0, a sample qualifies when `smp_data >= cfg_level` (unsigned); a sample equal to the threshold qualifies.
- R3: With `cfg_below` = 1, a sample qualifies when `smp_data < cfg_level`; a sample equal to the threshold does not qualify.
- R4: From `ST_LOW`, the flag rises after `cfg_set_runs` consecutive qualifying valid samples. It is visible one clock after the edge that accepts the completing sample (arm complete).
- R5: From `ST_HIGH`, the flag falls after `cfg_clr_runs` consecutive non-qualifying valid samples, with the same one-clock timing (release complete).
- R6: A valid sample that breaks the current run resets that run's count to zero, so a full new run is needed.
- R7: Cycles with `smp_valid` low neither advance nor break a run and never change `flag_o`.
- R8: A programmed count of 0 behaves as 1. With a count of 1, the transition follows a single sample's comparison directly.
- R9: Counts up to 255 are honoured exactly: 254 samples are not enough and the 255th completes the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_below | input | 1 | Flag type: 0 = above (at or over), 1 = below (strictly under) |
| cfg_level | input | SAMPLE_W | Threshold |
| cfg_set_runs | input | CNT_W | Consecutive qualifying samples needed to set (0 acts as 1) |
| cfg_clr_runs | input | CNT_W | Consecutive non-qualifying samples needed to clear (0 acts as 1) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Filtered sample value |
| flag_o | output | 1 | Registered flag level |

## Verification
Two events can land on the same clock edge. One is the completion of a run, which moves the state. The other is the restart of both run counters. This matters most when the very next sample already argues for the opposite direction. The bench provokes it with counts of 1 and 0, alternating qualifying and non-qualifying samples, so that every accepted sample toggles the flag. It also switches the flag type while the flag is set, so that a sample at the threshold immediately starts a release run. A behavioural model built from integers and run lengths is compared with `flag_o` on every clock, alongside targeted checks one sample short of, and exactly at, each run boundary.

// File: rtl/thresh_flag_pkg.sv
package thresh_flag_pkg;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } flag_state_e;

    // A programmed run length of zero is treated as one.
    function automatic logic [7:0] floor_one8(input logic [7:0] raw);
        return (raw == 8'd0) ? 8'd1 : raw;
    endfunction

endpackage

// File: rtl/tf_qualify.sv
module tf_qualify #(
    parameter int SAMPLE_W = 12
) (
    input  logic                cmp_below,
    input  logic [SAMPLE_W-1:0] cmp_level,
    input  logic [SAMPLE_W-1:0] cmp_data,
    output logic                cmp_hit
);

    logic at_or_over;

    always_comb begin
        at_or_over = (cmp_data >= cmp_level);
        cmp_hit    = cmp_below ? !at_or_over : at_or_over;
    end

endmodule

// File: rtl/tf_run_counter.sv
module tf_run_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] run_limit,
    input  logic             run_clear,
    input  logic             run_bump,
    output logic             run_last
);

    localparam int EXT_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] eff_limit;
    logic [EXT_W-1:0] next_len;

    always_comb begin
        eff_limit = (run_limit == '0) ? CNT_W'(1) : run_limit;
        next_len  = {1'b0, count_q} + EXT_W'(1);
        // True when one more accepted sample would complete the run.
        run_last  = (next_len >= {1'b0, eff_limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (run_clear) begin
            count_q <= '0;
        end else if (run_bump && count_q != CNT_MAX) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tf_flag_fsm.sv
module tf_flag_fsm
    import thresh_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_take,
    input  logic smp_qual,
    input  logic set_last,
    input  logic clr_last,
    output logic set_bump,
    output logic set_clear,
    output logic clr_bump,
    output logic clr_clear,
    output logic flag
);

    flag_state_e state_q;
    flag_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and counter control
    always_comb begin
        state_d   = state_q;
        set_bump  = 1'b0;
        set_clear = 1'b0;
        clr_bump  = 1'b0;
        clr_clear = 1'b0;
        unique case (state_q)
            ST_LOW: begin
                clr_clear = 1'b1;
                if (smp_take) begin
                    if (smp_qual) begin
                        set_bump = 1'b1;
                        if (set_last) begin
                            state_d   = ST_HIGH;   // arm complete
                            set_clear = 1'b1;
                        end
                    end else begin
                        set_clear = 1'b1;          // run broken
                    end
                end
            end
            ST_HIGH: begin
                set_clear = 1'b1;
                if (smp_take) begin
                    if (!smp_qual) begin
                        clr_bump = 1'b1;
                        if (clr_last) begin
                            state_d   = ST_LOW;    // release complete
                            clr_clear = 1'b1;
                        end
                    end else begin
                        clr_clear = 1'b1;          // run broken
                    end
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        flag = (state_q == ST_HIGH);
    end

endmodule

// File: rtl/thresh_flag.sv
module thresh_flag #(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_below,
    input  logic [SAMPLE_W-1:0] cfg_level,
    input  logic [CNT_W-1:0]    cfg_set_runs,
    input  logic [CNT_W-1:0]    cfg_clr_runs,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                flag_o
);

    logic qual;
    logic set_last, clr_last;
    logic set_bump, set_clear, clr_bump, clr_clear;

    tf_qualify #(.SAMPLE_W(SAMPLE_W)) u_qualify (
        .cmp_below (cfg_below),
        .cmp_level (cfg_level),
        .cmp_data  (smp_data),
        .cmp_hit   (qual)
    );

    tf_run_counter #(.CNT_W(CNT_W)) u_set_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_limit (cfg_set_runs),
        .run_clear (set_clear),
        .run_bump  (set_bump),
        .run_last  (set_last)
    );

    tf_run_counter #(.CNT_W(CNT_W)) u_clr_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_limit (cfg_clr_runs),
        .run_clear (clr_clear),
        .run_bump  (clr_bump),
        .run_last  (clr_last)
    );

    tf_flag_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_take  (smp_valid),
        .smp_qual  (qual),
        .set_last  (set_last),
        .clr_last  (clr_last),
        .set_bump  (set_bump),
        .set_clear (set_clear),
        .clr_bump  (clr_bump),
        .clr_clear (clr_clear),
        .flag      (flag_o)
    );

endmodule

// File: rtl/thresh_flag_chk.sv
module thresh_flag_chk #(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_below,
    input logic [SAMPLE_W-1:0] cfg_level,
    input logic [CNT_W-1:0]    cfg_set_runs,
    input logic [CNT_W-1:0]    cfg_clr_runs,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic                flag_o
);

    logic ok_side;
    assign ok_side = cfg_below ? (smp_data < cfg_level) : (smp_data >= cfg_level);

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_low_r1: assert (flag_o == 1'b0);
        end
    end

    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_valid) |-> $stable(flag_o));

    p_rise_on_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(smp_valid && ok_side));

    p_fall_on_nonqual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(smp_valid && !ok_side));

    p_single_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && smp_valid && ok_side && cfg_set_runs <= CNT_W'(1)) |=> flag_o);

    p_single_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && smp_valid && !ok_side && cfg_clr_runs <= CNT_W'(1)) |=> !flag_o);

endmodule

bind thresh_flag thresh_flag_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_below    (cfg_below),
    .cfg_level    (cfg_level),
    .cfg_set_runs (cfg_set_runs),
    .cfg_clr_runs (cfg_clr_runs),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .flag_o       (flag_o)
);

// File: tb/tb_thresh_flag.sv
`timescale 1ns/1ps
module tb_thresh_flag;

    localparam int W = 12;
    localparam int C = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_below = 1'b0;
    logic [W-1:0] cfg_level = '0;
    logic [C-1:0] cfg_set_runs = 8'd1;
    logic [C-1:0] cfg_clr_runs = 8'd1;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         flag_o;

    always #4 clk = ~clk;   // 125 MHz

    thresh_flag #(.SAMPLE_W(W), .CNT_W(C)) dut (.*);

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    // Behavioural reference: flag level plus current run lengths.
    int m_flag = 0, m_run_set = 0, m_run_clr = 0;
    always @(posedge clk) begin
        int need_set, need_clr;
        bit good;
        need_set = (cfg_set_runs == 0) ? 1 : int'(cfg_set_runs);
        need_clr = (cfg_clr_runs == 0) ? 1 : int'(cfg_clr_runs);
        good = cfg_below ? (int'(smp_data) < int'(cfg_level))
                         : (int'(smp_data) >= int'(cfg_level));
        if (!rst_n) begin
            m_flag = 0; m_run_set = 0; m_run_clr = 0;
        end else if (smp_valid) begin
            if (m_flag == 0) begin
                m_run_clr = 0;
                m_run_set = good ? m_run_set + 1 : 0;
                if (m_run_set >= need_set) begin m_flag = 1; m_run_set = 0; end
            end else begin
                m_run_set = 0;
                m_run_clr = good ? 0 : m_run_clr + 1;
                if (m_run_clr >= need_clr) begin m_flag = 0; m_run_clr = 0; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (flag_o !== m_flag[0]) begin
                fails++;
                $display("FAIL %s per-cycle flag: actual %0b expected %0d", phase, flag_o, m_flag);
            end
        end
    end

    task automatic step(input bit v, input int d);
        @(posedge clk); #2;
        smp_valid = v;
        smp_data  = W'(d);
    endtask

    task automatic run(input int d, input int n);
        for (int i = 0; i < n; i++) step(1'b1, d);
    endtask

    // Lets the pending sample be captured, then checks the flag.
    task automatic peek(input string req, input bit exp);
        @(posedge clk); #2;
        smp_valid = 1'b0;
        #1;
        checks++;
        if (flag_o !== exp) begin
            fails++;
            $display("FAIL %s flag: actual %0b expected %0b", req, flag_o, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset holds the flag low even with qualifying samples.
        phase = "R1";
        step(1'b1, 50);
        peek("R1", 1'b0);
        @(posedge clk); #2; rst_n = 1'b1;
        step(1'b0, 0);
        peek("R1", 1'b0);

        // R2 / R4: above mode, threshold 100, set 5, clear 3.
        phase = "R4"; cfg_below = 1'b0; cfg_level = 12'd100;
        cfg_set_runs = 8'd5; cfg_clr_runs = 8'd3;
        run(100, 1); run(150, 1); run(4095, 1); run(100, 1);
        peek("R4", 1'b0);
        run(100, 1);
        peek("R2", 1'b1);

        // R5 / R6: release run broken by one qualifying sample.
        phase = "R6";
        run(99, 2); run(100, 1); run(99, 2);
        peek("R6", 1'b1);
        run(99, 1);
        peek("R5", 1'b0);

        // R6: arm run broken.
        run(120, 4); run(50, 1); run(120, 4);
        peek("R6", 1'b0);
        run(120, 1);
        peek("R4", 1'b1);

        // R7: invalid gaps neither break nor advance.
        phase = "R7";
        run(0, 3);
        peek("R5", 1'b0);
        for (int i = 0; i < 4; i++) begin step(1'b1, 200); step(1'b0, 0); end
        peek("R7", 1'b0);
        step(1'b1, 200);
        peek("R7", 1'b1);

        // R3: below mode, threshold 500, set 2, clear 2; flag currently set.
        phase = "R3"; cfg_below = 1'b1; cfg_level = 12'd500;
        cfg_set_runs = 8'd2; cfg_clr_runs = 8'd2;
        run(500, 2);
        peek("R3", 1'b0);
        run(499, 1);
        peek("R3", 1'b0);
        run(499, 1);
        peek("R3", 1'b1);

        // R8: count 0 acts as 1, count 1 follows each sample.
        phase = "R8"; cfg_set_runs = 8'd0; cfg_clr_runs = 8'd1;
        run(600, 1);
        peek("R8", 1'b0);
        run(10, 1);
        peek("R8", 1'b1);
        run(500, 1);
        peek("R8", 1'b0);
        run(10, 1); run(700, 1); run(5, 1);
        peek("R8", 1'b1);
        run(500, 1);
        peek("R8", 1'b0);

        // R9: full 8-bit counts in above mode, threshold 1000.
        phase = "R9"; cfg_below = 1'b0; cfg_level = 12'd1000;
        cfg_set_runs = 8'd255; cfg_clr_runs = 8'd255;
        run(1000, 254);
        peek("R9", 1'b0);
        run(1000, 1);
        peek("R9", 1'b1);
        run(999, 254);
        peek("R9", 1'b1);
        run(999, 1);
        peek("R9", 1'b0);

        step(1'b0, 0);
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule